// File: doc/BRIEF.md
# Addressed-Record Serial Boot Loader

This block fills RAM from a serial flash or EEPROM before a processor is allowed to run. When the reboot input is pulsed, it holds the processor in reset with its buses floated. It then opens a sequential read on the serial memory and streams records back to back. Each record is three bytes: a 16-bit target address, high byte first, followed by one data byte. The record is shifted into a chain of byte-wide shift registers. Their parallel outputs drive the RAM address and data lines, and the block then issues one write strobe.

The target address is carried inside every record, so the image can scatter bytes anywhere in the upper half of the address space. The address field also marks the end of the image. A record whose address bit 15 is clear stops the load. The block then writes nothing more, closes the serial read and releases the processor.

Top module: `serial_boot_loader`

## Requirements
- R1: During and after a synchronous reset, cpu_hold_o is 0, spi_cs_n_o is 1, spi_sck_o is 0 and ram_we_o is 0.
- R2: A reboot_i pulse sets cpu_hold_o on the next clock edge, with spi_cs_n_o still 1 for that cycle. spi_cs_n_o goes low one cycle later.
- R3: Each load begins with 24 bits on spi_mosi_o, most significant bit first, sampled on rising spi_sck_o: the read command 0x03, then a 16-bit start address of zero.
- R4: Each record is read as 24 bits, most significant bit first, captured on rising spi_sck_o. Bits 23..8 form the RAM address and bits 7..0 the data byte. The block then asserts ram_we_o for exactly one cycle with ram_addr_o and ram_data_o holding those fields.
- R5: Every record takes exactly 24 rising spi_sck_o edges. spi_sck_o stays low while ram_we_o is high, which pauses the serial read during the write.
- R6: A record whose address bit 15 (record bit 23) is 0 produces no write. On that record, spi_cs_n_o returns to 1 and cpu_hold_o falls on the same edge, and no further writes or clocks follow.
- R7: cpu_hold_o stays 1 for as long as spi_cs_n_o is 0.
- R8: A reboot_i pulse during a load abandons it. spi_cs_n_o goes high for one cycle, and the load restarts from the command and address zero.
- R9: After a finished load, a new reboot_i pulse starts a fresh load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reboot_i | input | 1 | Starts or restarts a load |
| spi_miso_i | input | 1 | Serial data from the memory |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_cs_n_o | output | 1 | Serial memory select, active low |
| spi_mosi_o | output | 1 | Command and address bits to the memory |
| ram_addr_o | output | 16 | RAM write address from the record |
| ram_data_o | output | 8 | RAM write data from the record |
| ram_we_o | output | 1 | One-cycle RAM write strobe |
| cpu_hold_o | output | 1 | Holds the processor in reset with buses floated |

## Verification
A wrong bit count or a slipped record boundary shows up at the first write. The address and data become bit-rotated mixtures of neighbouring records, and the number of serial clocks consumed no longer equals 24 per record. A stuck or misread end marker shows up one record later, as an extra write or as cpu_hold_o failing to drop while the select line rises. A bad header shows as a nonzero start address seen by the memory model before any data moves.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_HDR,
    ST_STREAM,
    ST_WRITE
  } ld_state_e;

  localparam logic [7:0] SPI_READ_CMD = 8'h03;
endpackage

// File: rtl/bootld_shift_stage.sv
module bootld_shift_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/bootld_load_latch.sv
module bootld_load_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic hold_o
);
  // set wins over clear: a reboot always re-arms
  always_ff @(posedge clk) begin
    if (rst)        hold_o <= 1'b0;
    else if (set_i) hold_o <= 1'b1;
    else if (clr_i) hold_o <= 1'b0;
  end

  assert_reboot_sets_R2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> hold_o);
endmodule

// File: rtl/bootld_sequencer.sv
module bootld_sequencer
  import bootld_pkg::*;
#(
  parameter int HDR_W = 24,
  parameter int REC_W = 24,
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rec_msb_i,
  output logic sck_o,
  output logic cs_n_o,
  output logic mosi_o,
  output logic shift_en_o,
  output logic we_o,
  output logic end_o
);
  localparam int SPI_AW = HDR_W - 8;

  ld_state_e          state;
  logic [HDR_W-1:0]   hdr;
  logic [CNT_W-1:0]   cnt;
  logic               rec_done;

  assign mosi_o     = hdr[HDR_W-1];
  assign shift_en_o = (state == ST_STREAM) && !sck_o;
  assign rec_done   = (state == ST_STREAM) && sck_o && (cnt == CNT_W'(REC_W));
  assign end_o      = rec_done && !rec_msb_i && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      hdr    <= '0;
      cnt    <= '0;
      sck_o  <= 1'b0;
      cs_n_o <= 1'b1;
      we_o   <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state  <= ST_ARM;
        cs_n_o <= 1'b1;
        sck_o  <= 1'b0;
        cnt    <= '0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ARM: begin
            state  <= ST_HDR;
            cs_n_o <= 1'b0;
            hdr    <= {SPI_READ_CMD, {SPI_AW{1'b0}}};
            cnt    <= '0;
          end
          ST_HDR: begin
            if (!sck_o) begin
              sck_o <= 1'b1;
              cnt   <= cnt + 1'b1;
            end else begin
              sck_o <= 1'b0;
              hdr   <= {hdr[HDR_W-2:0], 1'b0};
              if (cnt == CNT_W'(HDR_W)) begin
                cnt   <= '0;
                state <= ST_STREAM;
              end
            end
          end
          ST_STREAM: begin
            if (!sck_o) begin
              sck_o <= 1'b1;
              cnt   <= cnt + 1'b1;
            end else begin
              sck_o <= 1'b0;
              if (cnt == CNT_W'(REC_W)) begin
                cnt <= '0;
                if (rec_msb_i) begin
                  state <= ST_WRITE;
                  we_o  <= 1'b1;
                end else begin
                  state  <= ST_IDLE;
                  cs_n_o <= 1'b1;
                end
              end
            end
          end
          ST_WRITE: state <= ST_STREAM;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_we_pauses_sck_R5: assert property (@(posedge clk) disable iff (rst)
    we_o |-> !sck_o);
  assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(REC_W > HDR_W ? REC_W : HDR_W));
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (!sck_o && !we_o));
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SPI_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reboot_i,
  input  logic              spi_miso_i,
  output logic              spi_sck_o,
  output logic              spi_cs_n_o,
  output logic              spi_mosi_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              ram_we_o,
  output logic              cpu_hold_o
);
  localparam int REC_W   = ADDR_W + DATA_W;
  localparam int NSTG    = REC_W / DATA_W;
  localparam int HDR_W   = 8 + SPI_AW;
  localparam int CNT_MAX = (REC_W > HDR_W) ? REC_W : HDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [REC_W-1:0] rec;
  logic             shift_en;
  logic             load_end;

  // daisy-chained byte registers: stage 0 takes the serial input
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic sin;
    if (g == 0) begin : g_head
      assign sin = spi_miso_i;
    end else begin : g_link
      assign sin = rec[g*DATA_W-1];
    end
    bootld_shift_stage #(.W(DATA_W)) u_stage (
      .clk (clk),
      .rst (rst),
      .en  (shift_en),
      .sin (sin),
      .q   (rec[g*DATA_W +: DATA_W])
    );
  end

  assign ram_addr_o = rec[REC_W-1:DATA_W];
  assign ram_data_o = rec[DATA_W-1:0];

  bootld_sequencer #(
    .HDR_W (HDR_W),
    .REC_W (REC_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (reboot_i),
    .rec_msb_i  (rec[REC_W-1]),
    .sck_o      (spi_sck_o),
    .cs_n_o     (spi_cs_n_o),
    .mosi_o     (spi_mosi_o),
    .shift_en_o (shift_en),
    .we_o       (ram_we_o),
    .end_o      (load_end)
  );

  bootld_load_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_i  (reboot_i),
    .clr_i  (load_end),
    .hold_o (cpu_hold_o)
  );

  assert_hold_while_sel_R7: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n_o |-> cpu_hold_o);
  assert_release_on_marker_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_hold_o) |-> (spi_cs_n_o && !rec[REC_W-1]));
  assert_write_high_half_R4: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> ram_addr_o[ADDR_W-1]);
endmodule

// File: tb/serial_boot_loader_bench.sv
module serial_boot_loader_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, reboot = 1'b0, miso = 1'b0;
  logic        sck, cs_n, mosi, we, hold;
  logic [15:0] addr;
  logic [7:0]  data;

  serial_boot_loader u_serial_boot_loader (
    .clk(clk), .rst(rst), .reboot_i(reboot), .spi_miso_i(miso),
    .spi_sck_o(sck), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi),
    .ram_addr_o(addr), .ram_data_o(data), .ram_we_o(we), .cpu_hold_o(hold)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0]  mem [0:255];
  logic [15:0] exp_addr [0:63];
  logic [7:0]  exp_data [0:63];
  int          exp_n = 0, widx = 0, bitcnt = 0;
  logic [23:0] hdr_got = '0;
  bit          wd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // serial memory model: samples on rising sck, drives on falling sck
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) bitcnt = 0;
    else begin
      if (bitcnt < 24) hdr_got = {hdr_got[22:0], mosi};
      bitcnt++;
    end
  end
  always @(negedge sck) begin
    if (!cs_n && bitcnt >= 24) begin
      int k;
      k = bitcnt - 24 + (hdr_got[15:0] * 8);
      miso = mem[(k / 8) % 256][7 - (k % 8)];
    end
  end

  // RAM-side monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (we) begin
        if (widx < exp_n) begin
          check(addr == exp_addr[widx], "R4", "write address", addr, exp_addr[widx]);
          check(data == exp_data[widx], "R4", "write data", data, exp_data[widx]);
          check(bitcnt - 24 == 24 * (widx + 1), "R5", "record bits consumed",
                bitcnt - 24, 24 * (widx + 1));
        end else check(0, "R6", "write after end marker", addr, 0);
        check(!sck, "R5", "sck during write", sck, 0);
        widx++;
      end
      if (!cs_n && !hold) check(0, "R7", "hold low while selected", hold, 1);
    end
  end

  function automatic logic [15:0] pick_addr(input int i, input bit directed);
    if (directed && i == 0) return 16'hFFFF;
    if (directed && i == 1) return 16'h8000;
    return {1'b1, 15'($urandom)};
  endfunction

  task automatic build(input int n, input logic [15:0] end_addr, input bit directed);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      exp_addr[i] = pick_addr(i, directed);
      exp_data[i] = 8'($urandom);
      mem[3*i]   = exp_addr[i][15:8];
      mem[3*i+1] = exp_addr[i][7:0];
      mem[3*i+2] = exp_data[i];
    end
    mem[3*n]   = end_addr[15:8];
    mem[3*n+1] = end_addr[7:0];
    exp_n = n;
  endtask

  task automatic pulse(input string req);
    @(negedge clk);
    reboot = 1'b1; widx = 0; hdr_got = 24'hFFFFFF;
    @(negedge clk);
    reboot = 1'b0;
    check(hold == 1'b1, req, "hold after reboot", hold, 1);
    check(cs_n == 1'b1, req, "select in arm cycle", cs_n, 1);
    @(negedge clk);
    check(cs_n == 1'b0, req, "select one cycle later", cs_n, 0);
  endtask

  task automatic finish_load(input string req);
    while (hold && !wd) @(negedge clk);
    check(widx == exp_n, req, "write count at end", widx, exp_n);
    check(cs_n == 1'b1 && sck == 1'b0, req, "serial bus idle at end", {cs_n, sck}, 2);
    check(hdr_got == 24'h030000, "R3", "read command and start address", hdr_got, 24'h030000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(!hold && cs_n && !sck && !we, "R1", "reset outputs", {hold, cs_n, sck, we}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    check(!hold && cs_n && !sck && !we, "R1", "idle after reset", {hold, cs_n, sck, we}, 4'b0100);

    // random image
    build(20, 16'h0000, 0);
    pulse("R2");
    finish_load("R6");

    // directed boundary addresses, marker with all other bits set
    build(6, 16'h7FFF, 1);
    pulse("R2");
    finish_load("R6");

    // marker in the first record: no writes at all
    build(0, 16'h1234, 0);
    pulse("R2");
    finish_load("R6");

    // idle after done: nothing moves
    repeat (100) @(negedge clk);
    check(widx == 0 && !hold && cs_n, "R6", "quiet after end", widx, 0);

    // restart in the middle of a load
    build(10, 16'h0042, 0);
    pulse("R8");
    while (widx < 4 && !wd) @(negedge clk);
    pulse("R8");
    finish_load("R8");

    // fresh load after a finished one
    build(30, 16'h0000, 0);
    pulse("R9");
    finish_load("R9");

    if (wd) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule